// File: doc/BRIEF.md
# Power Mode Sequencer

This block steps a small processor core between three operating states: full-speed run, wait-for-interrupt, and halt. Software drives it with two one-cycle request strobes, one for a wait instruction and one for a halt instruction. It returns synchronous clock-enable signals for the core, the peripherals and the interrupt controller. It also returns a control that puts the I/O pads into high impedance, and a two-bit code that reports the current state.

In wait, the core enable is off. The peripheral and interrupt-controller enables keep running, slowed down by a power-of-two divider that software sets while in run. An interrupt that is both requested and acknowledged brings the block back to run. A halt request stops every enable and floats the pads, but only when the watchdog is off. With the watchdog on, the same request gives wait mode, so the watchdog keeps its clock. Only reset leaves halt.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: In run (status 00), cpu_clk_en, per_clk_en and intc_clk_en are all 1 on every cycle and io_hiz is 0.
- R2: A wfi_req sampled in run moves the block to wait on the next cycle: status 01, cpu_clk_en 0, io_hiz 0.
- R3: In wait, per_clk_en and intc_clk_en pulse for one cycle once every N cycles. N is set by the divider code: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8. The first pulse falls on the Nth cycle spent in wait.
- R4: In wait, irq_req and irq_ack both high in the same cycle return the block to run on the next cycle. irq_ack without irq_req is ignored.
- R5: A halt_req sampled in run with wdog_en at 0 moves the block to halt on the next cycle: status 10, all three enables 0, io_hiz 1.
- R6: Halt is left only through reset. irq_req, irq_ack, wfi_req, halt_req and div_wr have no effect while halted.
- R7: A halt_req sampled in run with wdog_en at 1 moves the block to wait (status 01), not to halt.
- R8: When wfi_req and halt_req are both sampled in run, the halt request decides the outcome: halt if wdog_en is 0, wait if it is 1.
- R9: div_wr loads div_sel into the divider code only when the block is in run. A write in wait or halt is ignored.
- R10: Synchronous active-low reset gives run mode, io_hiz 0 and divider code 00 (divide by 1).
- R11: In wait, wfi_req and halt_req are ignored. The block stays in wait whatever the state of wdog_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock from the clock unit |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | One-cycle wait-for-interrupt request from the core |
| halt_req | input | 1 | One-cycle halt request from the core |
| irq_req | input | 1 | An interrupt request is pending |
| irq_ack | input | 1 | The interrupt controller acknowledges the request |
| wdog_en | input | 1 | Watchdog is enabled |
| div_wr | input | 1 | Write strobe for the wait-mode divider code |
| div_sel | input | 2 | Divider code: 00 gives /1, 01 gives /2, 10 gives /4, 11 gives /8 |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| intc_clk_en | output | 1 | Interrupt controller clock enable |
| io_hiz | output | 1 | Drive I/O pads to high impedance |
| mode_stat | output | 2 | Current state: 00 run, 01 wait, 10 halt |

## Verification
Two things can land in the same cycle. First, a wait request and a halt request can be raised together. The bench does this with the watchdog both off and on, and expects halt in the first case and wait in the second. Second, a divider write can arrive in the very cycle of a wait request. The write is still taken because the block is in run, so the pulse spacing counted over the following wait window must match the new code. A behavioural reference model is compared against every output on every clock throughout.

// File: rtl/pmc_pkg.sv
// Package: shared state encoding and divider helpers for the power mode sequencer.
// Assumes the status code values are visible to software and must not change.
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_WAIT = 2'b01,
        PM_HALT = 2'b10
    } pm_mode_e;

    localparam int DIV_CODE_W = 2;
endpackage

// File: rtl/pmc_mode_fsm.sv
// Module: pmc_mode_fsm
// Holds the operating state and applies the transition rules: run to wait on a wait
// request, run to halt on a halt request with the watchdog off (otherwise wait),
// wait to run on an acknowledged interrupt, and halt left only by reset.
// Assumes request strobes and interrupt lines are synchronous to clk.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wfi_req,
    input  logic     halt_req,
    input  logic     wdog_en,
    input  logic     irq_req,
    input  logic     irq_ack,
    output pm_mode_e mode_q
);
    pm_mode_e mode_d;

    // Next-state decision; halt request outranks wait request.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            PM_RUN: begin
                if (halt_req)
                    mode_d = wdog_en ? PM_WAIT : PM_HALT;
                else if (wfi_req)
                    mode_d = PM_WAIT;
            end
            PM_WAIT: begin
                if (irq_req && irq_ack)
                    mode_d = PM_RUN;
            end
            PM_HALT: mode_d = PM_HALT;
            default: mode_d = PM_RUN;
        endcase
    end

    // State register with synchronous reset to run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= PM_RUN;
        else
            mode_q <= mode_d;
    end

    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_HALT) |=> (mode_q == PM_HALT));

    a_r4_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_WAIT && irq_req && irq_ack) |=> (mode_q == PM_RUN));

    a_r7_wdog_keeps_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_RUN && halt_req && wdog_en) |=> (mode_q == PM_WAIT));

    a_r5_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_RUN && halt_req && !wdog_en) |=> (mode_q == PM_HALT));

    a_r11_wait_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_WAIT && !(irq_req && irq_ack)) |=> (mode_q == PM_WAIT));

    a_r10_reset_run: assert property (@(posedge clk)
        (!rst_n) |=> (mode_q == PM_RUN));
endmodule

// File: rtl/pmc_clk_div.sv
// Module: pmc_clk_div
// Holds the software divider code and produces a one-cycle enable pulse once every
// 2**code cycles while in wait. The counter is held at zero outside wait, so the
// first pulse lands on the Nth wait cycle. Writes are taken only when wr_ok is high.
// Assumes wr_ok is high only in run mode.
module pmc_clk_div #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_wait,
    input  logic              wr_ok,
    input  logic              div_wr,
    input  logic [CODE_W-1:0] div_sel,
    output logic              tick
);
    localparam int N_CODES = 1 << CODE_W;
    localparam int CNT_W   = (N_CODES > 1) ? (N_CODES - 1) : 1;

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lim;

    // Terminal count for the selected ratio (ratio minus one).
    always_comb lim = CNT_W'((64'd1 << code_q) - 64'd1);

    // Divider code register; software may change it only from run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (div_wr && wr_ok)
            code_q <= div_sel;
    end

    // Phase counter, running only in wait and wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_wait)
            cnt_q <= '0;
        else if (cnt_q == lim)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Pulse on the terminal count while waiting.
    always_comb tick = in_wait && (cnt_q == lim);

    a_r9_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok) |=> $stable(code_q));

    a_r3_tick_only_wait: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> in_wait);

    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= lim) || !in_wait);
endmodule

// File: rtl/pmc_out_gate.sv
// Module: pmc_out_gate
// Turns the state and the divider pulse into the clock enables, the pad float control
// and the status code. Purely combinational.
// Assumes tick is low outside wait.
module pmc_out_gate
    import pmc_pkg::*;
(
    input  pm_mode_e    mode,
    input  logic        tick,
    output logic        cpu_en,
    output logic        per_en,
    output logic        intc_en,
    output logic        hiz,
    output logic [1:0]  stat
);
    // Enable selection per state.
    always_comb begin
        cpu_en = 1'b0;
        per_en = 1'b0;
        hiz    = 1'b0;
        unique case (mode)
            PM_RUN:  begin cpu_en = 1'b1; per_en = 1'b1; end
            PM_WAIT: per_en = tick;
            PM_HALT: hiz = 1'b1;
            default: begin cpu_en = 1'b1; per_en = 1'b1; end
        endcase
        intc_en = per_en;
        stat    = mode;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Power mode sequencer: run / wait-for-interrupt / halt, with a divided peripheral
// rate in wait and pads floated in halt. Enables are synchronous clock enables.
// Assumes all inputs are synchronous to clk.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int CODE_W = DIV_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wfi_req,
    input  logic              halt_req,
    input  logic              irq_req,
    input  logic              irq_ack,
    input  logic              wdog_en,
    input  logic              div_wr,
    input  logic [CODE_W-1:0] div_sel,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              intc_clk_en,
    output logic              io_hiz,
    output logic [1:0]        mode_stat
);
    pm_mode_e mode_q;
    logic     div_tick;

    pmc_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wfi_req  (wfi_req),
        .halt_req (halt_req),
        .wdog_en  (wdog_en),
        .irq_req  (irq_req),
        .irq_ack  (irq_ack),
        .mode_q   (mode_q)
    );

    pmc_clk_div #(.CODE_W(CODE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_wait (mode_q == PM_WAIT),
        .wr_ok   (mode_q == PM_RUN),
        .div_wr  (div_wr),
        .div_sel (div_sel),
        .tick    (div_tick)
    );

    pmc_out_gate u_out (
        .mode    (mode_q),
        .tick    (div_tick),
        .cpu_en  (cpu_clk_en),
        .per_en  (per_clk_en),
        .intc_en (intc_clk_en),
        .hiz     (io_hiz),
        .stat    (mode_stat)
    );

    a_r2_wait_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b01) |-> (!cpu_clk_en && !io_hiz));

    a_r5_halt_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b10) |-> (io_hiz && !cpu_clk_en && !per_clk_en && !intc_clk_en));

    a_r1_run_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b00) |-> (cpu_clk_en && per_clk_en && intc_clk_en && !io_hiz));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wfi_req = 1'b0, halt_req = 1'b0, irq_req = 1'b0, irq_ack = 1'b0;
    logic       wdog_en = 1'b0, div_wr = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       cpu_clk_en, per_clk_en, intc_clk_en, io_hiz;
    logic [1:0] mode_stat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    int m_mode  = 0;   // 0 run, 1 wait, 2 halt
    int m_ratio = 1;
    int m_cnt   = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    pwr_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .halt_req(halt_req),
        .irq_req(irq_req), .irq_ack(irq_ack), .wdog_en(wdog_en), .div_wr(div_wr),
        .div_sel(div_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .intc_clk_en(intc_clk_en), .io_hiz(io_hiz), .mode_stat(mode_stat)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update on the active edge
    always @(posedge clk) begin
        int nxt;
        if (!rst_n) begin
            m_mode = 0; m_ratio = 1; m_cnt = 0;
        end else begin
            nxt = m_mode;
            if (m_mode == 0) begin
                if (halt_req) nxt = wdog_en ? 1 : 2;
                else if (wfi_req) nxt = 1;
                if (div_wr) m_ratio = 1 << div_sel;
            end else if (m_mode == 1) begin
                if (irq_req && irq_ack) nxt = 0;
            end
            if (m_mode == 1) m_cnt = (m_cnt + 1) % m_ratio;
            else m_cnt = 0;
            m_mode = nxt;
        end
    end

    // Compare every output against the model away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            int e_per;
            e_per = (m_mode == 0) ? 1 : (m_mode == 1) ? ((m_cnt == m_ratio - 1) ? 1 : 0) : 0;
            chk((m_mode == 0) ? "R1 mode_stat" : (m_mode == 1) ? "R2 mode_stat" : "R5 mode_stat",
                int'(mode_stat), m_mode);
            chk("R1/R2 cpu_clk_en", int'(cpu_clk_en), (m_mode == 0) ? 1 : 0);
            chk("R3 per_clk_en", int'(per_clk_en), e_per);
            chk("R3 intc_clk_en", int'(intc_clk_en), e_per);
            chk("R5 io_hiz", int'(io_hiz), (m_mode == 2) ? 1 : 0);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wfi();
        wfi_req = 1'b1; step(); wfi_req = 1'b0;
    endtask

    task automatic wake();
        irq_req = 1'b1; irq_ack = 1'b1; step(); irq_req = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (per_clk_en) cnt++;
            step();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(3); rst_n = 1'b1;
    endtask

    initial begin
        int pc;
        do_reset();
        // R10: reset state
        chk("R10 status after reset", int'(mode_stat), 0);
        chk("R10 io_hiz after reset", int'(io_hiz), 0);
        chk("R1 cpu enable in run", int'(cpu_clk_en), 1);
        step(2);

        // R10: divider defaults to /1
        pulse_wfi();
        chk("R2 status wait", int'(mode_stat), 1);
        count_pulses(8, pc);
        chk("R10 default divide-by-1 pulses", pc, 8);
        // R4: ack without request ignored
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        chk("R4 ack alone ignored", int'(mode_stat), 1);
        wake();
        chk("R4 wake to run", int'(mode_stat), 0);

        // R3: each divider code
        for (int c = 1; c < 4; c++) begin
            div_sel = 2'(c); div_wr = 1'b1; step(); div_wr = 1'b0;
            pulse_wfi();
            count_pulses(16, pc);
            chk($sformatf("R3 pulses code %0d", c), pc, 16 >> c);
            wake();
            step(2);
        end

        // R9: write during wait ignored (code 01, /2)
        div_sel = 2'b01; div_wr = 1'b1; step(); div_wr = 1'b0;
        pulse_wfi();
        div_sel = 2'b11; div_wr = 1'b1; step(); div_wr = 1'b0;
        count_pulses(16, pc);
        chk("R9 write in wait ignored", pc, 8);
        // R11: halt and wfi requests in wait ignored
        wdog_en = 1'b0; halt_req = 1'b1; wfi_req = 1'b1; step(); halt_req = 1'b0; wfi_req = 1'b0;
        chk("R11 requests ignored in wait", int'(mode_stat), 1);
        wake();

        // Same cycle: div write with wfi request (write taken from run)
        div_sel = 2'b10; div_wr = 1'b1; wfi_req = 1'b1; step(); div_wr = 1'b0; wfi_req = 1'b0;
        count_pulses(16, pc);
        chk("R9 write with wfi accepted", pc, 4);
        wake();
        step();

        // R7: halt with watchdog on becomes wait
        wdog_en = 1'b1; halt_req = 1'b1; step(); halt_req = 1'b0;
        chk("R7 halt with watchdog -> wait", int'(mode_stat), 1);
        chk("R7 pads not floated", int'(io_hiz), 0);
        wake();

        // R8: both requests, watchdog on -> wait
        wfi_req = 1'b1; halt_req = 1'b1; step(); wfi_req = 1'b0; halt_req = 1'b0;
        chk("R8 both requests, watchdog on", int'(mode_stat), 1);
        wake();
        wdog_en = 1'b0;

        // R8: both requests, watchdog off -> halt (R5)
        wfi_req = 1'b1; halt_req = 1'b1; step(); wfi_req = 1'b0; halt_req = 1'b0;
        chk("R8 both requests, watchdog off", int'(mode_stat), 2);
        chk("R5 io_hiz in halt", int'(io_hiz), 1);
        chk("R5 per enable off", int'(per_clk_en), 0);

        // R6: nothing leaves halt except reset
        wake(); wake();
        pulse_wfi();
        div_sel = 2'b00; div_wr = 1'b1; step(); div_wr = 1'b0;
        chk("R6 halt sticky", int'(mode_stat), 2);
        chk("R6 cpu still off", int'(cpu_clk_en), 0);
        do_reset();
        chk("R6 reset leaves halt", int'(mode_stat), 0);
        chk("R10 hiz cleared by reset", int'(io_hiz), 0);

        // R10: divider cleared by reset after code 10
        pulse_wfi();
        count_pulses(8, pc);
        chk("R10 divider cleared by reset", pc, 8);
        wake();

        // R5: plain halt from run
        halt_req = 1'b1; step(); halt_req = 1'b0;
        chk("R5 halt entry", int'(mode_stat), 2);
        step(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog against a hung run
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule